// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a serial chain of boundary cells placed between a device's pads and its core logic. Every functional input pin passes through an input cell on its way to the core. Every core output passes through an output cell on its way to its pad. Each cell has three parts: a capture stage, an update stage and a selector. The capture stage either loads the value arriving at the cell in parallel or takes the serial bit from its upstream neighbour. The update stage copies the capture stage on request. The selector passes either the functional value or the update stage.

An external test-access controller drives the chain through a capture/shift clock enable (`clock_dr`), a shift select (`shift_dr`), an update enable (`update_dr`) and a two-bit mode. All of these are qualified by the single fabric clock. The same structure covers three uses; only the mode changes between them:
- Sampling: pins are captured while the device runs normally.
- Board interconnect test: output pads are driven from the update stages.
- Core test: the core is driven and observed from the chain and is isolated from the pads.

The serial path runs from `sin` through input cells 0 to N_IN-1, then through output cells 0 to N_OUT-1, and ends at `sout`.

Top module: `bscan_chain`

## Requirements
- R1: A synchronous high `rst` clears every capture stage and every update stage to 0 on the next clock edge. Because of this, `sout` is 0 after reset and the pads read 0 in a test mode until the first update.
- R2: On an edge with `clock_dr`=1 and `shift_dr`=0, input cell i captures `pin_in[i]` and output cell j captures `core_out[j]`.
- R3: On an edge with `clock_dr`=1 and `shift_dr`=1, the first input cell takes `sin` and every other cell takes the old value of the cell before it. `sout` always equals the last output cell's capture stage, so the last output cell leaves first.
- R4: On an edge with `clock_dr`=0, every capture stage holds its value, whatever `shift_dr`, `sin` and the pins do.
- R5: On an edge with `update_dr`=1, every update stage loads the capture stage's value from before that edge. With `update_dr`=0 the update stages hold, including while shifting continues.
- R6: In mode 2'b00 (functional/sample), `core_in`=`pin_in` and `pin_out`=`core_out`, with no clock delay.
- R7: In mode 2'b01 (board test), `pin_out` shows the output cells' update stages and `core_in` still follows `pin_in`.
- R8: In mode 2'b10 (core test), `core_in` shows the input cells' update stages and `pin_out` shows the output cells' update stages, so the core is cut off from the pads in both directions.
- R9: Mode 2'b11 behaves exactly like mode 2'b00.
- R10: When `clock_dr` and `update_dr` are both 1 on the same edge, the update stages receive the capture values from before that edge. They do not receive the newly captured or shifted values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock qualifying all chain actions |
| rst | input | 1 | Synchronous active-high chain reset |
| mode | input | 2 | 00 functional, 01 board test, 10 core test, 11 as 00 |
| clock_dr | input | 1 | Capture/shift enable for this edge |
| shift_dr | input | 1 | 1 selects serial shift, 0 selects parallel capture |
| update_dr | input | 1 | Update-stage load enable for this edge |
| sin | input | 1 | Serial data into the first input cell |
| sout | output | 1 | Serial data from the last output cell |
| pin_in | input | N_IN | Values arriving from input pads |
| core_in | output | N_IN | Values presented to the core inputs |
| core_out | input | N_OUT | Values produced by the core outputs |
| pin_out | output | N_OUT | Values driven toward output pads |

## Verification
The chain is exercised with several kinds of pattern, and each one isolates a different fault:
- Random pad and core values in functional mode check the pass-through paths.
- A parallel capture followed by a full unload shows whether the capture sources are wired to the right cells and in the right serial order.
- Long shift-in runs with `update_dr` low, followed by a single update, separate the holding behaviour of the update stages from their loading.
- Each of the four mode codes is applied over the same loaded latches, so a mux select swapped between input and output cells shows up at once.
- Edges with `shift_dr` toggling but `clock_dr` low, and edges with capture and update together, cover the ordering corners.
- A reset in the middle of a run confirms that the state clears.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {
    TM_FUNC   = 2'b00,
    TM_BOARD  = 2'b01,
    TM_CORE   = 2'b10,
    TM_SPARE  = 2'b11
  } test_mode_e;
endpackage

// File: rtl/bscan_mode_dec.sv
module bscan_mode_dec
  import bscan_pkg::*;
(
  input  logic [1:0] mode,
  output logic       drive_core,
  output logic       drive_pins
);
  test_mode_e m;

  always_comb begin
    m          = test_mode_e'(mode);
    drive_core = 1'b0;
    drive_pins = 1'b0;
    case (m)
      TM_BOARD: drive_pins = 1'b1;
      TM_CORE: begin
        drive_core = 1'b1;
        drive_pins = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic clk,
  input  logic rst,
  input  logic par_in,
  input  logic ser_in,
  input  logic func_in,
  input  logic clock_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic sel_latch,
  output logic cap_q,
  output logic upd_q,
  output logic func_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      if (clock_dr)  cap_q <= shift_dr ? ser_in : par_in;
      if (update_dr) upd_q <= cap_q;
    end
  end

  assign func_out = sel_latch ? upd_q : func_in;
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             clock_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             sin,
  output logic             sout,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pin_out
);
  localparam int LEN = N_IN + N_OUT;

  logic [LEN-1:0] cap_q;
  logic [LEN-1:0] upd_q;
  logic [LEN-1:0] ser_in;
  logic [LEN-1:0] par_in;
  logic [LEN-1:0] func_out;
  logic           drive_core;
  logic           drive_pins;

  bscan_mode_dec u_dec (
    .mode       (mode),
    .drive_core (drive_core),
    .drive_pins (drive_pins)
  );

  // Cells 0..N_IN-1 sit on inputs, the rest on outputs.
  assign par_in = {core_out, pin_in};
  assign ser_in = {cap_q[LEN-2:0], sin};

  for (genvar k = 0; k < LEN; k++) begin : g_cell
    logic sel;
    if (k < N_IN) begin : g_in
      assign sel = drive_core;
    end else begin : g_out
      assign sel = drive_pins;
    end

    bscan_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .par_in    (par_in[k]),
      .ser_in    (ser_in[k]),
      .func_in   (par_in[k]),
      .clock_dr  (clock_dr),
      .shift_dr  (shift_dr),
      .update_dr (update_dr),
      .sel_latch (sel),
      .cap_q     (cap_q[k]),
      .upd_q     (upd_q[k]),
      .func_out  (func_out[k])
    );
  end

  assign core_in = func_out[N_IN-1:0];
  assign pin_out = func_out[LEN-1:N_IN];
  assign sout    = cap_q[LEN-1];
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic [1:0]             mode,
  input logic                   clock_dr,
  input logic                   shift_dr,
  input logic                   update_dr,
  input logic                   sin,
  input logic                   sout,
  input logic [N_IN-1:0]        pin_in,
  input logic [N_IN-1:0]        core_in,
  input logic [N_OUT-1:0]       core_out,
  input logic [N_OUT-1:0]       pin_out,
  input logic [N_IN+N_OUT-1:0]  cap,
  input logic [N_IN+N_OUT-1:0]  upd
);
  localparam int LEN = N_IN + N_OUT;

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cap == '0 && upd == '0));

  // R2
  capture_src_chk: assert property (@(posedge clk) disable iff (rst)
    (clock_dr && !shift_dr) |=> cap == $past({core_out, pin_in}));

  // R3
  shift_step_chk: assert property (@(posedge clk) disable iff (rst)
    (clock_dr && shift_dr) |=> cap == $past({cap[LEN-2:0], sin}));

  // R3
  sout_tap_chk: assert property (@(posedge clk) disable iff (rst)
    sout == cap[LEN-1]);

  // R4
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clock_dr |=> $stable(cap));

  // R5
  upd_load_chk: assert property (@(posedge clk) disable iff (rst)
    update_dr |=> upd == $past(cap));

  // R5
  upd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !update_dr |=> $stable(upd));

  // R6
  func_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 || mode == 2'b11) |-> (core_in == pin_in && pin_out == core_out));

  // R7
  board_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |-> (pin_out == upd[LEN-1:N_IN] && core_in == pin_in));

  // R8
  core_iso_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |-> (core_in == upd[N_IN-1:0] && pin_out == upd[LEN-1:N_IN]));
endmodule

bind bscan_chain bscan_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode      (mode),
  .clock_dr  (clock_dr),
  .shift_dr  (shift_dr),
  .update_dr (update_dr),
  .sin       (sin),
  .sout      (sout),
  .pin_in    (pin_in),
  .core_in   (core_in),
  .core_out  (core_out),
  .pin_out   (pin_out),
  .cap       (cap_q),
  .upd       (upd_q)
);

// File: tb/tb_bscan_chain.sv
`timescale 1ns/1ps
module tb_bscan_chain;
  localparam int NI  = 4;
  localparam int NO  = 3;
  localparam int LEN = NI + NO;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode = 2'b00;
  logic          clock_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, sin = 1'b0;
  logic          sout;
  logic [NI-1:0] pin_in = '0;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out = '0;
  logic [NO-1:0] pin_out;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  // behavioural model: bit queues indexed by serial position
  bit cap_m[LEN];
  bit upd_m[LEN];

  always #2.5 clk = ~clk;

  bscan_chain #(.N_IN(NI), .N_OUT(NO)) dut (
    .clk(clk), .rst(rst), .mode(mode), .clock_dr(clock_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .sin(sin), .sout(sout), .pin_in(pin_in),
    .core_in(core_in), .core_out(core_out), .pin_out(pin_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b01:   return "R7";
      2'b10:   return "R8";
      2'b11:   return "R9";
      default: return "R6";
    endcase
  endfunction

  // compare outputs against model before the edge, then advance both
  task automatic step(string tag);
    logic [NI-1:0] ci_e;
    logic [NO-1:0] po_e;
    bit nc[LEN];
    #1;
    for (int i = 0; i < NI; i++)
      ci_e[i] = (mode == 2'b10) ? upd_m[i] : pin_in[i];
    for (int j = 0; j < NO; j++)
      po_e[j] = (mode == 2'b01 || mode == 2'b10) ? upd_m[NI+j] : core_out[j];
    cmp({tag, "/sout"}, 32'(sout), 32'(cap_m[LEN-1]));
    cmp({mode_tag(mode), "/core_in"}, 32'(core_in), 32'(ci_e));
    cmp({mode_tag(mode), "/pin_out"}, 32'(pin_out), 32'(po_e));
    @(posedge clk);
    if (rst) begin
      foreach (cap_m[k]) begin cap_m[k] = 0; upd_m[k] = 0; end
    end else begin
      if (update_dr) foreach (upd_m[k]) upd_m[k] = cap_m[k];
      if (clock_dr) begin
        for (int k = 0; k < LEN; k++) begin
          if (shift_dr) nc[k] = (k == 0) ? sin : cap_m[k-1];
          else          nc[k] = (k < NI) ? pin_in[k] : core_out[k-NI];
        end
        cap_m = nc;
      end
    end
    @(negedge clk);
  endtask

  task automatic set_ctl(bit c, bit s, bit u, bit d);
    clock_dr = c; shift_dr = s; update_dr = u; sin = d;
  endtask

  initial begin
    foreach (cap_m[k]) begin cap_m[k] = 0; upd_m[k] = 0; end
    @(negedge clk);
    // R1: reset, then check cleared state in board-test mode
    repeat (2) step("R1");
    rst = 1'b0;
    mode = 2'b01;
    step("R1");
    cmp("R1/pin_out_zero", 32'(pin_out), 32'd0);

    // R6: functional pass-through with random values
    mode = 2'b00;
    for (int n = 0; n < 8; n++) begin
      pin_in = NI'($urandom); core_out = NO'($urandom);
      step("R6");
    end

    // R2 + R3: capture then unload serially
    pin_in = 4'b1011; core_out = 3'b010;
    set_ctl(1, 0, 0, 0); step("R2");
    for (int n = 0; n < LEN; n++) begin
      set_ctl(1, 1, 0, 1'(n & 1)); step("R3");
    end

    // R4: shift_dr/sin/pins toggle with clock_dr low
    for (int n = 0; n < 6; n++) begin
      set_ctl(0, 1'(n & 1), 0, 1'(~n & 1));
      pin_in = NI'($urandom); core_out = NO'($urandom);
      step("R4");
    end

    // R5: shift a pattern in without update, then update
    for (int n = 0; n < LEN; n++) begin
      set_ctl(1, 1, 0, 1'($urandom)); step("R5");
    end
    set_ctl(0, 0, 1, 0); step("R5");
    set_ctl(1, 1, 0, 1); step("R5");
    set_ctl(1, 1, 0, 0); step("R5");
    set_ctl(0, 0, 0, 0);

    // R7 R8 R9: all modes over the same latches
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int n = 0; n < 4; n++) begin
        pin_in = NI'($urandom); core_out = NO'($urandom);
        step(mode_tag(mode));
      end
    end

    // R10: capture and update on the same edge
    mode = 2'b10;
    pin_in = 4'b0110; core_out = 3'b101;
    set_ctl(1, 0, 1, 0); step("R10");
    set_ctl(0, 0, 0, 0); step("R10");
    set_ctl(0, 0, 1, 0); step("R10");
    step("R10");

    // random mix across all controls
    for (int n = 0; n < 200; n++) begin
      mode = 2'($urandom);
      set_ctl(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      pin_in = NI'($urandom); core_out = NO'($urandom);
      step("R3");
    end

    // R1: reset mid-run
    mode = 2'b10; set_ctl(0, 0, 0, 0);
    rst = 1'b1; step("R1");
    rst = 1'b0; step("R1");
    cmp("R1/core_in_zero", 32'(core_in), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule